// File: doc/BRIEF.md
# Low/Full-Speed NRZI Line Transmitter

This block turns a stream of packet bytes into the two-wire differential line signalling of a low-speed or full-speed serial bus. An upstream packet builder offers bytes on a valid/ready interface. The block sends each byte least significant bit first, one bit per cycle in which the bit-clock enable `bit_en` is high.

Each packet opens with a fixed synchronisation byte. The block inserts a zero after every run of six ones and NRZI-encodes the result onto the line. It closes the packet with two bit times of single-ended zero and one bit time of the idle state, then releases the output enable. The analog driver, high-speed signalling and CRC generation sit outside this block.

The controller has seven states:
- `S_IDLE`: the line rests at J and the enable is off.
- `S_SYNC`: the synchronisation byte goes out.
- `S_DATA`: payload bytes go out.
- `S_FLUSH`: a stuffed bit that falls after the final payload bit goes out.
- `S_SE0A` and `S_SE0B`: the two end-of-packet SE0 bit times.
- `S_EOPJ`: the closing J bit.

The transitions are:
- IDLE→SYNC when `in_valid` is seen on a bit enable.
- SYNC→DATA and DATA→DATA on a byte acceptance.
- SYNC/DATA→FLUSH when the final bit completes a run of six ones.
- SYNC/DATA→SE0A otherwise at packet end.
- FLUSH→SE0A.
- SE0A→SE0B→EOPJ→IDLE.

A stuffed bit is sent from SYNC or DATA without leaving the state. The output enable drops on the first bit enable spent in IDLE with no new packet waiting.

Top module: `nrzi_line_tx`

## Requirements
- R1: After reset `line_oe` is 0, the line shows J (`line_p`=1, `line_n`=0) and `in_ready` is 0.
- R2: While idle the line shows J with `line_oe` low. A bit enable with `in_valid` high starts a packet: after that edge `line_oe` is 1 and the line shows K (`line_p`=0, `line_n`=1).
- R3: Every packet begins with the byte 0x80 sent LSB first (seven 0 bits, then a 1), giving the line sequence K J K J K J K K.
- R4: Line encoding is NRZI: a 0 bit toggles the line between J and K, and a 1 bit holds it. The line changes only on edges where `bit_en` is high.
- R5: Payload bytes are sent LSB first. A byte is taken on an edge where `in_valid` and `in_ready` are both high. `in_ready` is high only during a bit enable in the last bit slot of the sync byte or of a payload byte not tagged last, and never while a stuffed bit is sent.
- R6: After six consecutive 1 bits a 0 bit is inserted. The count runs across the sync byte and across byte boundaries.
- R7: If the final payload bit completes a run of six ones, the stuffed 0 is still sent before the end of packet.
- R8: The end of packet is two bit times of SE0 (both lines low), then one bit time of J. `line_oe` falls at the next bit enable unless a new packet starts there.
- R9: A packet ends after the byte accepted with `in_last` high. It also ends if `in_valid` is low when `in_ready` asks for the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle pulse per bit time |
| in_data | input | 8 | Payload byte offered by the packet builder |
| in_valid | input | 1 | Payload byte is valid |
| in_last | input | 1 | Offered byte is the last of the packet |
| in_ready | output | 1 | Block takes the offered byte at this edge |
| line_p | output | 1 | Positive data line level |
| line_n | output | 1 | Negative data line level |
| line_oe | output | 1 | Line driver enable |

## Verification
The case hardest to reach from the ports is a stuffed bit whose position lands exactly after the last payload bit, or exactly on a byte boundary where `in_ready` must stay low. No directed pattern list finds all such alignments. The bench therefore sends every one of the 256 single-byte payloads, which puts runs of ones at every offset relative to the sync byte's trailing 1 and to the end of packet. It then adds multi-byte packets of long one-runs that straddle byte boundaries, and a truncated packet ended by a valid dropout. An arithmetic model in the bench predicts each bit time of line state from the bits alone.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SYNC,
        S_DATA,
        S_FLUSH,
        S_SE0A,
        S_SE0B,
        S_EOPJ
    } tx_state_t;

    typedef enum logic [1:0] {
        LC_HOLD,
        LC_TOGGLE,
        LC_SE0,
        LC_J
    } line_cmd_t;

endpackage

// File: rtl/nrzi_run_tracker.sv
module nrzi_run_tracker #(
    parameter int RUN_LIMIT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic bit_val,
    input  logic stuff_tx,
    output logic stuff_due,
    output logic run_full_next
);
    localparam int RW = $clog2(RUN_LIMIT + 1);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (clr || stuff_tx || (adv && !bit_val)) begin
            run_q <= '0;
        end else if (adv) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign stuff_due     = (run_q == RW'(RUN_LIMIT));
    assign run_full_next = adv && bit_val && (run_q == RW'(RUN_LIMIT - 1));

    // R6
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(RUN_LIMIT));

endmodule

// File: rtl/nrzi_line_drv.sv
module nrzi_line_drv
    import nrzi_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step,
    input  line_cmd_t cmd,
    input  logic      oe_set,
    input  logic      oe_clr,
    output logic      line_p,
    output logic      line_n,
    output logic      line_oe
);
    logic k_q;
    logic se0_q;
    logic oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q   <= 1'b0;
            se0_q <= 1'b0;
            oe_q  <= 1'b0;
        end else if (step) begin
            unique case (cmd)
                LC_HOLD:   k_q <= k_q;
                LC_TOGGLE: k_q <= ~k_q;
                LC_SE0:    se0_q <= 1'b1;
                LC_J: begin
                    k_q   <= 1'b0;
                    se0_q <= 1'b0;
                end
            endcase
            if (oe_set) begin
                oe_q <= 1'b1;
            end else if (oe_clr) begin
                oe_q <= 1'b0;
            end
        end
    end

    assign line_p  = !se0_q && !k_q;
    assign line_n  = !se0_q && k_q;
    assign line_oe = oe_q;

    // R2
    idle_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_q |-> (!se0_q && !k_q));

endmodule

// File: rtl/nrzi_line_tx.sv
module nrzi_line_tx
    import nrzi_tx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int RUN_LIMIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              line_p,
    output logic              line_n,
    output logic              line_oe
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  CNT_MAX   = CNT_W'(BYTE_W - 1);
    localparam logic [BYTE_W-1:0] SYNC_WORD = BYTE_W'(1) << (BYTE_W - 1);

    tx_state_t         st_q;
    tx_state_t         st_nxt;
    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              last_q;

    line_cmd_t cmd;
    logic oe_on, oe_off;
    logic clr, adv, stuff_tx;
    logic load_sync, load_byte, shift;
    logic stuff_due, run_full_next;

    nrzi_run_tracker #(.RUN_LIMIT(RUN_LIMIT)) u_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .adv          (adv),
        .bit_val      (sh_q[0]),
        .stuff_tx     (stuff_tx),
        .stuff_due    (stuff_due),
        .run_full_next(run_full_next)
    );

    nrzi_line_drv u_drv (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (bit_en),
        .cmd    (cmd),
        .oe_set (oe_on),
        .oe_clr (oe_off),
        .line_p (line_p),
        .line_n (line_n),
        .line_oe(line_oe)
    );

    assign in_ready = bit_en && !stuff_due && (cnt_q == CNT_MAX) &&
                      ((st_q == S_SYNC) || ((st_q == S_DATA) && !last_q));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // next state and per-bit actions
    always_comb begin
        st_nxt    = st_q;
        cmd       = LC_HOLD;
        oe_on     = 1'b0;
        oe_off    = 1'b0;
        clr       = 1'b0;
        adv       = 1'b0;
        stuff_tx  = 1'b0;
        load_sync = 1'b0;
        load_byte = 1'b0;
        shift     = 1'b0;
        if (bit_en) begin
            unique case (st_q)
                S_IDLE: begin
                    if (in_valid) begin
                        cmd       = LC_TOGGLE;
                        oe_on     = 1'b1;
                        clr       = 1'b1;
                        load_sync = 1'b1;
                        st_nxt    = S_SYNC;
                    end else begin
                        oe_off = 1'b1;
                    end
                end
                S_SYNC, S_DATA: begin
                    if (stuff_due) begin
                        cmd      = LC_TOGGLE;
                        stuff_tx = 1'b1;
                    end else begin
                        cmd   = sh_q[0] ? LC_HOLD : LC_TOGGLE;
                        adv   = 1'b1;
                        shift = 1'b1;
                        if (cnt_q == CNT_MAX) begin
                            if (in_ready && in_valid) begin
                                load_byte = 1'b1;
                                st_nxt    = S_DATA;
                            end else begin
                                st_nxt = run_full_next ? S_FLUSH : S_SE0A;
                            end
                        end
                    end
                end
                S_FLUSH: begin
                    cmd      = LC_TOGGLE;
                    stuff_tx = 1'b1;
                    st_nxt   = S_SE0A;
                end
                S_SE0A: begin
                    cmd    = LC_SE0;
                    st_nxt = S_SE0B;
                end
                S_SE0B: begin
                    cmd    = LC_SE0;
                    st_nxt = S_EOPJ;
                end
                S_EOPJ: begin
                    cmd    = LC_J;
                    st_nxt = S_IDLE;
                end
                default: st_nxt = S_IDLE;
            endcase
        end
    end

    // byte shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            last_q <= 1'b0;
        end else if (load_sync) begin
            sh_q   <= SYNC_WORD >> 1;
            cnt_q  <= CNT_W'(1);
            last_q <= 1'b0;
        end else if (load_byte) begin
            sh_q   <= in_data;
            cnt_q  <= '0;
            last_q <= in_last;
        end else if (shift) begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6
    stuff_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && stuff_due) |=> (line_p != $past(line_p)));

    // R2
    start_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> (!line_p && line_n));

    // R8
    eop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_oe) |-> (line_p && !line_n));

    // R8
    se0_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_SE0B) |-> (!line_p && !line_n && line_oe));

    // R5
    no_take_on_stuff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && stuff_due) |=> $stable(cnt_q));

endmodule

// File: tb/test_nrzi_line_tx.sv
module test_nrzi_line_tx;
    localparam int PERIOD = 10;
    localparam int DIV    = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       line_p, line_n, line_oe;

    int checks = 0;
    int errors = 0;

    logic [2:0] exp_s [0:127];
    int         exp_len;
    logic [7:0] pk [0:3];

    always #(PERIOD/2) clk = ~clk;

    nrzi_line_tx i_nrzi_line_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .in_data (in_data),
        .in_valid(in_valid),
        .in_last (in_last),
        .in_ready(in_ready),
        .line_p  (line_p),
        .line_n  (line_n),
        .line_oe (line_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Model: {oe,p,n}; K=101, J=110, SE0=100, idle=010
    task automatic build_model(input int nb);
        int  run = 0;
        bit  k = 1'b0;
        int  n = 0;
        bit  bits [0:39];
        int  nbits = 0;
        for (int i = 0; i < 8; i++) begin
            bits[nbits] = (i == 7);
            nbits++;
        end
        for (int b = 0; b < nb; b++) begin
            for (int i = 0; i < 8; i++) begin
                bits[nbits] = pk[b][i];
                nbits++;
            end
        end
        for (int i = 0; i < nbits; i++) begin
            if (run == 6) begin
                k = ~k;
                exp_s[n] = {1'b1, !k, k};
                n++;
                run = 0;
            end
            if (bits[i]) run++;
            else begin
                k = ~k;
                run = 0;
            end
            exp_s[n] = {1'b1, !k, k};
            n++;
        end
        if (run == 6) begin
            k = ~k;
            exp_s[n] = {1'b1, !k, k};
            n++;
        end
        exp_s[n] = 3'b100; n++;
        exp_s[n] = 3'b100; n++;
        exp_s[n] = 3'b110; n++;
        exp_s[n] = 3'b010; n++;
        exp_len = n;
    endtask

    task automatic run_packet(input int nb, input bit tag_last, input string req);
        int  idx = 0;
        int  nsamp = 0;
        int  cyc = 0;
        int  mism = 0;
        int  first_bad = -1;
        int  bad_act = 0;
        int  accepts = 0;
        int  hold_bad = 0;
        bit  started = 0;
        bit  prev_en = 0;
        bit  en;
        logic [2:0] cur;
        logic [2:0] last_seen = 3'b010;
        build_model(nb);
        while (nsamp < exp_len && cyc < 2000) begin
            @(negedge clk);
            cur = {line_oe, line_p, line_n};
            if (prev_en && started) begin
                if (cur !== exp_s[nsamp]) begin
                    mism++;
                    if (first_bad < 0) begin
                        first_bad = nsamp;
                        bad_act = int'(cur);
                    end
                end
                nsamp++;
                last_seen = cur;
            end else if (started && cur !== last_seen) begin
                // R4: line moves only on bit enables
                hold_bad++;
            end
            en = (cyc % DIV) == (DIV - 1);
            cyc++;
            bit_en   = en;
            in_valid = (idx < nb);
            in_data  = (idx < nb) ? pk[idx] : 8'h00;
            in_last  = tag_last && (idx == nb - 1);
            #1;
            if (en && !started && in_valid) started = 1;
            else if (in_valid && in_ready) begin
                idx++;
                accepts++;
            end
            prev_en = en;
        end
        @(negedge clk);
        bit_en = 1'b0;
        in_valid = 1'b0;
        in_last = 1'b0;
        chk(mism == 0, req, $sformatf("line sample %0d", first_bad), bad_act,
            (first_bad >= 0) ? int'(exp_s[first_bad]) : 0);
        chk(hold_bad == 0, "R4", "line moved without bit_en", hold_bad, 0);
        // R5: every offered byte taken exactly once
        chk(accepts == nb, "R5", "bytes accepted", accepts, nb);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(line_oe == 1'b0, "R1", "oe after reset", int'(line_oe), 0);
        chk({line_p, line_n} == 2'b10, "R1", "line after reset",
            int'({line_p, line_n}), 2);
        bit_en = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R1", "ready in reset", int'(in_ready), 0);
        bit_en = 1'b0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R2: idle bit enables keep J and oe low
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        chk({line_oe, line_p, line_n} == 3'b010, "R2", "idle line",
            int'({line_oe, line_p, line_n}), 2);

        // R3 R4 R6 R7 R8: every single-byte payload
        for (int v = 0; v < 256; v++) begin
            pk[0] = v[7:0];
            run_packet(1, 1'b1, "R3/R4/R6/R7/R8 single byte");
        end

        // R6: runs of ones across byte boundaries
        pk[0] = 8'hFF; pk[1] = 8'hFF; pk[2] = 8'hFF; pk[3] = 8'hFF;
        run_packet(4, 1'b1, "R6 all ones");
        pk[0] = 8'hF0; pk[1] = 8'h0F; pk[2] = 8'hE0; pk[3] = 8'h07;
        run_packet(4, 1'b1, "R6 straddling runs");
        // R7: last byte ends in six ones after a long run
        pk[0] = 8'hFF; pk[1] = 8'hFC;
        run_packet(2, 1'b1, "R7 tail stuff");
        pk[0] = 8'h55; pk[1] = 8'hAA; pk[2] = 8'h3C;
        run_packet(3, 1'b1, "R4/R5 mixed bytes");
        // R9: valid dropout ends the packet without in_last
        pk[0] = 8'h7E; pk[1] = 8'h81;
        run_packet(2, 1'b0, "R9 underrun end");
        pk[0] = 8'hC3;
        run_packet(1, 1'b0, "R9 underrun single");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule